// File: doc/BRIEF.md
# Remote DMA Word Port Engine

This block lets a host reach a local packet buffer memory through a single 16-bit data port, one programmed I/O access at a time. The host loads a start address and a byte count as pairs of byte-wide registers. It then issues a command that arms a remote read or a remote write.

Every data-port access that follows moves one word between the port and the buffer. Each access steps the address up and the count down. When the count runs out, the block raises a completion flag. The host clears that flag by writing a one to it.

The buffer is arranged in 256-byte pages. Writing a page number into the address high byte, with the low byte at zero, therefore points the engine at the start of that page. An abort command drops a transfer that is still in progress and leaves the completion flag alone.

Top module: `rdma_word_port`

## Requirements
- R1: After reset the engine is idle: `busy` = 0, `dma_done` = 0, `dp_rdata` = 0, and the address and count registers hold zero.
- R2: Register writes (`reg_wr` = 1) decode `reg_addr` as follows:
  - 0 is the address low byte, 1 the address high byte.
  - 2 is the count low byte, 3 the count high byte.
  - 4 is the command register, 5 the status register.
  - The byte address equals the high byte times 256 plus the low byte, so loading page P with low byte 0 selects byte address P*256.
- R3: While a transfer is armed and the count is nonzero, each matching data-port access moves one 16-bit word. The access must be `dp_wr` in write mode or `dp_rd` in read mode. The address then rises by 2 and the count falls by 2. On a read, `dp_rdata` shows the word at the current address before the strobe.
- R4: Command byte encoding:
  - Bits [4:3] = 01 selects read, 10 selects write, 11 is abort, and 00 leaves the mode unchanged.
  - Bit 0 is start. Read or write with start = 0 leaves the engine stopped.
  - `busy` is 1 exactly when a read or write is armed and the count is nonzero.
- R5: An odd count still ends with a full word access, and that access brings the count to zero. On a read the upper byte of that last word reads as 0x00. The low byte, which holds the byte at the even address, is returned intact.
- R6: `dma_done` sets in the cycle after the access that brings the count to zero. Writing status with bit 0 = 1 clears it, and writing status with bit 0 = 0 leaves it set.
- R7: Accesses in the wrong direction, or with the count at zero, change neither the memory nor the count. Data-port reads return 0 whenever no read is armed.
- R8: An abort drops `busy` at once and does not set `dma_done`. Later data-port accesses are ignored.
- R9: Word addresses wrap modulo 2^MEM_AW bytes, so a transfer that runs past the top of the buffer continues at byte address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| dp_rd | input | 1 | Data-port read strobe |
| dp_wr | input | 1 | Data-port write strobe |
| dp_wdata | input | 16 | Data-port write word |
| dp_rdata | output | 16 | Data-port read word |
| busy | output | 1 | Transfer armed with count remaining |
| dma_done | output | 1 | Remote transfer complete flag |

## Verification
The bench builds the engine with MEM_AW = 10, which gives a 1 KiB buffer of four pages. That size puts the top-of-buffer wrap within reach of a four-byte transfer started two bytes below 0x400. It also lets transfers in pages 0 to 3 be written and then read back without disturbing one another. Odd counts, direction mismatches, aborts mid-transfer and both values of the status clear bit are all driven against data written earlier by the vector loop.

// File: rtl/rdma_word_port.sv
module rdma_word_port #(
  parameter int MEM_AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        dp_rd,
  input  logic        dp_wr,
  input  logic [15:0] dp_wdata,
  output logic [15:0] dp_rdata,
  output logic        busy,
  output logic        dma_done
);
  localparam int WORDS = 1 << (MEM_AW - 1);
  localparam logic [1:0] M_IDLE = 2'd0, M_RD = 2'd1, M_WR = 2'd2;

  logic [15:0] addr_q, cnt_q;
  logic [1:0]  mode_q;
  logic        done_q;
  logic [15:0] mem [WORDS];

  wire [MEM_AW-2:0] widx = addr_q[MEM_AW-1:1];
  wire [15:0] cnt_nxt = (cnt_q < 16'd2) ? 16'd0 : cnt_q - 16'd2;
  wire take = !reg_wr && busy &&
              ((mode_q == M_RD && dp_rd) || (mode_q == M_WR && dp_wr));
  wire [15:0] word = mem[widx];

  assign busy     = (mode_q != M_IDLE) && (cnt_q != 16'd0);
  assign dma_done = done_q;
  assign dp_rdata = (busy && mode_q == M_RD) ?
                    {(cnt_q == 16'd1) ? 8'h00 : word[15:8], word[7:0]} : 16'h0000;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      mode_q <= M_IDLE;
      done_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: addr_q[7:0]  <= reg_wdata;
        3'd1: addr_q[15:8] <= reg_wdata;
        3'd2: cnt_q[7:0]   <= reg_wdata;
        3'd3: cnt_q[15:8]  <= reg_wdata;
        3'd4: begin
          case (reg_wdata[4:3])
            2'b01:   mode_q <= reg_wdata[0] ? M_RD : M_IDLE;
            2'b10:   mode_q <= reg_wdata[0] ? M_WR : M_IDLE;
            2'b11:   mode_q <= M_IDLE;
            default: mode_q <= mode_q;
          endcase
        end
        3'd5: if (reg_wdata[0]) done_q <= 1'b0;
        default: ;
      endcase
    end else if (take) begin
      addr_q <= addr_q + 16'd2;
      cnt_q  <= cnt_nxt;
      if (cnt_nxt == 16'd0) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take && mode_q == M_WR) mem[widx] <= dp_wdata;
  end

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt_q >= 16'd2) |=> (cnt_q == $past(cnt_q) - 16'd2 && addr_q == $past(addr_q) + 16'd2));

  p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && cnt_q <= 16'd2) |=> (dma_done && !busy));

  p_idle_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dp_rdata == 16'h0000));

  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 3'd4 && reg_wdata[4:3] == 2'b11) |=> (!busy && dma_done == $past(dma_done)));

  p_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr && !busy) |=> $stable(cnt_q));
endmodule

// File: tb/rdma_word_port_bench.sv
module rdma_word_port_bench;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, dp_rd = 0, dp_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [15:0] dp_wdata = 0;
  logic [15:0] dp_rdata;
  logic busy, dma_done;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rdma_word_port #(.MEM_AW(10)) u_rdma_word_port (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .dp_rd(dp_rd), .dp_wr(dp_wr), .dp_wdata(dp_wdata),
    .dp_rdata(dp_rdata), .busy(busy), .dma_done(dma_done));

  localparam logic [47:0] VEC [5] = '{
    {16'h0000, 16'd8,  16'hA5A5},
    {16'h0100, 16'd6,  16'h1234},
    {16'h0200, 16'd2,  16'h0F0F},
    {16'h02F0, 16'd16, 16'hC3C3},
    {16'h0380, 16'd10, 16'h7777}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rw(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] n, input logic [7:0] cmd);
    rw(3'd0, a[7:0]); rw(3'd1, a[15:8]); rw(3'd2, n[7:0]); rw(3'd3, n[15:8]); rw(3'd4, cmd);
  endtask

  task automatic wr_word(input logic [15:0] d);
    dp_wr = 1; dp_wdata = d;
    @(negedge clk); dp_wr = 0;
  endtask

  task automatic rd_word(input string tag, input logic [15:0] exp);
    check(tag, dp_rdata, exp);
    dp_rd = 1;
    @(negedge clk); dp_rd = 0;
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 done", {15'd0, dma_done}, 16'd0);
    check("R1 rdata", dp_rdata, 16'd0);
    rst_n = 1; @(negedge clk);
    rw(3'd4, 8'h09);
    check("R1 count zero after reset, busy", {15'd0, busy}, 16'd0);

    for (int v = 0; v < 5; v++) begin
      logic [15:0] a, n, s;
      {a, n, s} = VEC[v];
      setup(a, n, 8'h11);
      check("R4 write armed busy", {15'd0, busy}, 16'd1);
      for (int i = 0; i < n / 2; i++) wr_word(s ^ 16'(i));
      check("R6 done after write", {15'd0, dma_done}, 16'd1);
      check("R3 write count exhausted", {15'd0, busy}, 16'd0);
      rw(3'd5, 8'h01);
      check("R6 cleared", {15'd0, dma_done}, 16'd0);
      setup(a, n, 8'h09);
      for (int i = 0; i < n / 2; i++) rd_word("R3 readback", s ^ 16'(i));
      check("R6 done after read", {15'd0, dma_done}, 16'd1);
      rw(3'd5, 8'h01);
    end

    // R2: page 3 via high byte = 3 gives 0x300
    setup(16'h0300, 16'd2, 8'h11); wr_word(16'h3A3A);
    setup(16'h0000, 16'd0, 8'h00);
    rw(3'd0, 8'h00); rw(3'd1, 8'h03); rw(3'd2, 8'h02); rw(3'd3, 8'h00); rw(3'd4, 8'h09);
    rd_word("R2 page address", 16'h3A3A);

    // R6: status write with bit0 = 0 keeps flag
    check("R6 set before", {15'd0, dma_done}, 16'd1);
    rw(3'd5, 8'h00);
    check("R6 zero write keeps", {15'd0, dma_done}, 16'd1);
    rw(3'd5, 8'h01);

    // R5: odd read count
    setup(16'h0000, 16'd3, 8'h09);
    rd_word("R5 first word", 16'hA5A5);
    rd_word("R5 last word upper zero", {8'h00, 8'hA4});
    check("R5 done", {15'd0, dma_done}, 16'd1);
    rd_word("R7 read after zero count", 16'h0000);
    rw(3'd5, 8'h01);

    // R5: odd write count
    setup(16'h0300, 16'd3, 8'h11);
    wr_word(16'h1111); wr_word(16'h2222);
    check("R5 odd write done", {15'd0, dma_done}, 16'd1);
    check("R5 odd write idle", {15'd0, busy}, 16'd0);
    rw(3'd5, 8'h01);
    setup(16'h0300, 16'd4, 8'h09);
    rd_word("R5 odd write word0", 16'h1111);
    rd_word("R5 odd write word1", 16'h2222);
    rw(3'd5, 8'h01);

    // R9: wrap
    setup(16'h03FE, 16'd4, 8'h11);
    wr_word(16'hBEEF); wr_word(16'hCAFE);
    rw(3'd5, 8'h01);
    setup(16'h03FE, 16'd4, 8'h09);
    rd_word("R9 top word", 16'hBEEF);
    rd_word("R9 wrapped word", 16'hCAFE);
    rw(3'd5, 8'h01);

    // R7: wrong direction
    setup(16'h0100, 16'd2, 8'h09);
    wr_word(16'hDEAD);
    check("R7 still busy", {15'd0, busy}, 16'd1);
    rd_word("R7 memory untouched", 16'h1234);
    rw(3'd5, 8'h01);

    // R4: stop bit
    setup(16'h0100, 16'd2, 8'h08);
    check("R4 no start not busy", {15'd0, busy}, 16'd0);
    check("R4 no start rdata", dp_rdata, 16'h0000);

    // R8: abort
    setup(16'h0380, 16'd6, 8'h11);
    wr_word(16'h5555);
    rw(3'd4, 8'h18);
    check("R8 busy dropped", {15'd0, busy}, 16'd0);
    check("R8 done not set", {15'd0, dma_done}, 16'd0);
    wr_word(16'h6666);
    check("R8 done still clear", {15'd0, dma_done}, 16'd0);
    setup(16'h0380, 16'd4, 8'h09);
    rd_word("R8 written before abort", 16'h5555);
    rd_word("R8 ignored after abort", 16'h7776);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule